// File: doc/BRIEF.md
# Palette entry colour converter

This block takes the raw palette words that a display fetch engine reads from memory and turns each one into a uniform entry of one transparency bit followed by 8-bit red, green and blue channels. Converted entries land in an internal 256-entry palette RAM. A pixel pipeline looks them up through a registered read port indexed by pixel value.

A load begins with a one-cycle `loadStart`. The pixel depth code at that moment sets how many words follow. Each word presented with `srcValid` is converted and written in a single cycle, and `done` pulses once the final entry is in place. The raw words are also kept. If the palette format is changed later, a `frameStart` pulse replays them through the converter in the new format with no new fetch.

Top module: `pal_convert`

## Requirements
- R1: The depth code is `{depthHi, depthLo}`, with `depthHi` as bit 3. Codes 1, 2 and 3 load exactly 4, 16 and 256 entries, written at indices 0 upward.
- R2: Any other depth code, including code 9 (`depthHi`=1, `depthLo`=1), converts nothing. Words that follow are ignored, the palette contents stay the same and `done` stays low.
- R3: Format 0: red = word[15:11] in bits 7:3, green = word[10:5] in bits 7:2, blue = word[4:0] in bits 7:3. Unfilled low bits are 0 and transparency is 0 whatever word[24] holds.
- R4: Format 1 uses the format 0 colour layout, with transparency taken from word[24].
- R5: Format 2: red = word[23:19], green = word[15:10], blue = word[7:3]. Each is left-aligned in 8 bits with zero fill, and transparency = word[24].
- R6: Format 3: red, green and blue are word[23:16], word[15:8] and word[7:0], and transparency = word[24].
- R7: When `mono` is 1, all three channels equal word[7:0] in every format. Transparency still follows R3 to R6.
- R8: One entry is written per accepted word. `done` is high for exactly the one cycle after the clock edge that writes the last entry.
- R9: A `frameStart` pulse while idle, with a palette loaded and `palFmt` different from the format of the last conversion, re-converts every stored word. This takes one entry per cycle, and `done` follows as in R8 on the 4th, 16th or 256th cycle. When `palFmt` is unchanged, `frameStart` has no effect.
- R10: `rdEntry` returns the entry at `rdIdx` one clock later, packed as {transparency, R, G, B} in bits 24, 23:16, 15:8 and 7:0. A read and a write to the same index in one cycle return the old entry.
- R11: After reset, `done` is 0 and every palette entry reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStart | input | 1 | Begin a palette load using the current depth |
| srcValid | input | 1 | `srcWord` holds a palette word |
| srcWord | input | 32 | Raw palette word |
| depthLo | input | 3 | Low three bits of the pixel depth code |
| depthHi | input | 1 | Top bit of the pixel depth code |
| palFmt | input | 2 | Stored palette format, 0 to 3 |
| mono | input | 1 | Monochrome override |
| frameStart | input | 1 | Frame boundary; triggers re-conversion on a format change |
| rdIdx | input | 8 | Palette lookup index |
| rdEntry | output | 25 | Looked-up entry {t, R, G, B} |
| done | output | 1 | One-cycle pulse after the last entry is written |

## Verification
Two things can touch the same palette entry in one cycle: a pixel lookup and a conversion write. The bench provokes this by holding `rdIdx` on entry 0 while the first word of a new load is written there. The output after that edge must still show the entry from the earlier re-conversion, and the next cycle must show the new one. The replay path is judged by counting the cycles from `frameStart` to `done` and reading back every entry in the new format. A second `frameStart` with the format unchanged must leave the palette untouched.

// File: rtl/palconv_pkg.sv
package palconv_pkg;
  parameter int PAL_DEPTH = 256;
  parameter int IDX_W     = $clog2(PAL_DEPTH);
  parameter int CH_W      = 8;
  parameter int ENTRY_W   = 3 * CH_W + 1;
  parameter int KEEP_W    = 25;   // source bits that any format reads
  parameter int DEPTH_W   = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_REPLAY} palState_t;

  typedef struct packed {
    logic             wr;
    logic             replay;
    logic [IDX_W-1:0] idx;
  } palStrb_t;

  function automatic logic [IDX_W:0] entryCount(input logic [DEPTH_W-1:0] depth);
    case (depth)
      4'd1:    entryCount = (IDX_W+1)'(4);
      4'd2:    entryCount = (IDX_W+1)'(16);
      4'd3:    entryCount = (IDX_W+1)'(256);
      default: entryCount = '0;
    endcase
  endfunction

  function automatic logic [ENTRY_W-1:0] convWord(input logic [KEEP_W-1:0] w,
                                                  input logic [1:0] fmt,
                                                  input logic mono);
    logic [CH_W-1:0] r, g, b;
    logic t;
    case (fmt)
      2'd2: begin r = {w[23:19], 3'b0}; g = {w[15:10], 2'b0}; b = {w[7:3], 3'b0}; end
      2'd3: begin r = w[23:16];         g = w[15:8];          b = w[7:0];          end
      default: begin r = {w[15:11], 3'b0}; g = {w[10:5], 2'b0}; b = {w[4:0], 3'b0}; end
    endcase
    if (mono) begin
      r = w[7:0]; g = w[7:0]; b = w[7:0];
    end
    t = (fmt != 2'd0) & w[24];
    convWord = {t, r, g, b};
  endfunction
endpackage

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import palconv_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadStart,
  input  logic               srcValid,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [1:0]         palFmt,
  input  logic               frameStart,
  output palStrb_t           strb,
  output logic               done
);
  palState_t        st;
  logic [IDX_W-1:0] cnt, lastIdx;
  logic [1:0]       lastFmt;
  logic             loaded;
  logic [IDX_W:0]   nEntries;

  assign nEntries = entryCount(depth);

  always_comb begin
    strb.wr     = !loadStart && ((st == ST_LOAD && srcValid) || st == ST_REPLAY);
    strb.replay = (st == ST_REPLAY);
    strb.idx    = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= ST_IDLE; cnt <= '0; lastIdx <= '0; lastFmt <= '0;
      loaded <= 1'b0; done <= 1'b0;
    end else if (loadStart) begin
      loaded  <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      lastFmt <= palFmt;
      lastIdx <= IDX_W'(nEntries - 1'b1);
      st      <= (nEntries != '0) ? ST_LOAD : ST_IDLE;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (frameStart && loaded && palFmt != lastFmt) begin
          st <= ST_REPLAY; cnt <= '0; lastFmt <= palFmt;
        end
        default: if (strb.wr) begin
          if (cnt == lastIdx) begin
            done <= 1'b1; st <= ST_IDLE; loaded <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8: done only follows an entry write
  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(strb.wr));
  // R1: writes stay inside the loaded entry count
  a_r1_idx_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strb.wr |-> strb.idx <= lastIdx);
  // R9: a replay only begins after a frame boundary
  a_r9_replay_from_frame: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_REPLAY && $past(st) != ST_REPLAY) |-> $past(frameStart));
  // R2: an unsupported depth leaves the block idle
  a_r2_unsupported_idle: assert property (@(posedge clk) disable iff (!rstN)
    (loadStart && nEntries == '0) |=> (st == ST_IDLE && !strb.wr));
endmodule

// File: rtl/pal_dp.sv
module pal_dp
  import palconv_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  palStrb_t           strb,
  input  logic [KEEP_W-1:0]  srcWord,
  input  logic [1:0]         palFmt,
  input  logic               mono,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [ENTRY_W-1:0] rdEntry
);
  logic [KEEP_W-1:0]  rawBuf [PAL_DEPTH];
  logic [ENTRY_W-1:0] palRam [PAL_DEPTH];
  logic [KEEP_W-1:0]  wordSel;
  logic [ENTRY_W-1:0] newEntry;

  always_comb begin
    wordSel  = strb.replay ? rawBuf[strb.idx] : srcWord;
    newEntry = convWord(wordSel, palFmt, mono);
  end

  always_ff @(posedge clk) begin
    if (strb.wr && !strb.replay) rawBuf[strb.idx] <= srcWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAL_DEPTH; i++) palRam[i] <= '0;
      rdEntry <= '0;
    end else begin
      rdEntry <= palRam[rdIdx];
      if (strb.wr) palRam[strb.idx] <= newEntry;
    end
  end

  // R7: a monochrome write stores equal red and blue channels
  a_r7_mono_grey: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && mono) |=> palRam[$past(strb.idx)][23:16] == palRam[$past(strb.idx)][7:0]);
  // R3: format 0 entries are always opaque
  a_r3_fmt0_opaque: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && palFmt == 2'd0) |=> !palRam[$past(strb.idx)][24]);
endmodule

// File: rtl/pal_convert.sv
module pal_convert
  import palconv_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadStart,
  input  logic               srcValid,
  input  logic [31:0]        srcWord,
  input  logic [2:0]         depthLo,
  input  logic               depthHi,
  input  logic [1:0]         palFmt,
  input  logic               mono,
  input  logic               frameStart,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [ENTRY_W-1:0] rdEntry,
  output logic               done
);
  palStrb_t strb;
  logic     unusedHigh;

  assign unusedHigh = ^srcWord[31:KEEP_W];

  pal_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadStart(loadStart), .srcValid(srcValid),
    .depth({depthHi, depthLo}), .palFmt(palFmt), .frameStart(frameStart),
    .strb(strb), .done(done)
  );

  pal_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcWord(srcWord[KEEP_W-1:0]),
    .palFmt(palFmt), .mono(mono), .rdIdx(rdIdx), .rdEntry(rdEntry)
  );
endmodule

// File: tb/sim_pal_convert.sv
module sim_pal_convert;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        loadStart = 1'b0, srcValid = 1'b0, depthHi = 1'b0, mono = 1'b0, frameStart = 1'b0;
  logic [31:0] srcWord = '0;
  logic [2:0]  depthLo = '0;
  logic [1:0]  palFmt = '0;
  logic [7:0]  rdIdx = '0;
  logic [24:0] rdEntry;
  logic        done;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { logic [24:0] exp; string tag; } item_t;
  item_t scq[$];
  logic rdReq = 1'b0, capReq = 1'b0;

  logic [31:0] srcMem [256];
  logic [24:0] expPal [256];

  pal_convert u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [24:0] model(input logic [31:0] w, input logic [1:0] f, input logic m);
    logic [7:0] r, g, b;
    logic t;
    if (f == 2'd3)      begin r = 8'(w >> 16);            g = 8'(w >> 8);            b = w[7:0]; end
    else if (f == 2'd2) begin r = 8'(w >> 16) & 8'hF8;    g = 8'(w >> 8) & 8'hFC;    b = w[7:0] & 8'hF8; end
    else                begin r = 8'(w >> 8) & 8'hF8;     g = 8'(w >> 3) & 8'hFC;    b = 8'(w << 3) & 8'hF8; end
    if (m) begin r = w[7:0]; g = w[7:0]; b = w[7:0]; end
    t = (f != 2'd0) ? w[24] : 1'b0;
    return {t, r, g, b};
  endfunction

  // monitor: compare each lookup one cycle after it was issued
  always @(posedge clk) capReq <= rdReq;
  always @(negedge clk) begin
    if (capReq && scq.size() > 0) begin
      item_t it;
      it = scq.pop_front();
      chk(rdEntry == it.exp, it.tag, 32'(rdEntry), 32'(it.exp));
    end
  end

  task automatic readChk(input int idx, input logic [24:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    rdIdx = 8'(idx); rdReq = 1'b1;
    it.exp = exp; it.tag = tag;
    scq.push_back(it);
    @(posedge clk); #1 rdReq = 1'b0;
  endtask

  task automatic loadPal(input logic [2:0] lo, input logic hi, input logic [1:0] f,
                         input logic m, input int n, input logic [31:0] seed,
                         input bit gaps, input string tag);
    bit supported = (hi == 1'b0) && (lo >= 3'd1) && (lo <= 3'd3);
    @(negedge clk);
    depthLo = lo; depthHi = hi; palFmt = f; mono = m; loadStart = 1'b1;
    @(negedge clk);
    loadStart = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      w = (seed * 32'(i + 1)) ^ (32'(i) << 20) ^ 32'h0100_0000;
      if (supported) begin srcMem[i] = w; expPal[i] = model(w, f, m); end
      srcWord = w; srcValid = 1'b1;
      if (i > 0) chk(done == 1'b0, {tag, " R8 done early"}, 32'(done), 0);
      @(negedge clk);
      srcValid = 1'b0;
      if (gaps && (i % 2 == 1) && i < n - 1) @(negedge clk);
    end
    chk(done == supported, {tag, supported ? " R8 done after last" : " R2 no done"}, 32'(done), 32'(supported));
    @(negedge clk);
    chk(done == 1'b0, {tag, " R8 done one cycle"}, 32'(done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(done == 1'b0, "R11 done after reset", 32'(done), 0);
    readChk(5, 25'h0, "R11 entry 5 zero");
    readChk(255, 25'h0, "R11 entry 255 zero");

    // R1 R3: 256 entries, format 0, transparency forced off
    loadPal(3'd3, 1'b0, 2'd0, 1'b0, 256, 32'h1357_9BDF, 1'b0, "R1 depth3");
    readChk(0, expPal[0], "R3 fmt0 e0");
    readChk(77, expPal[77], "R3 fmt0 e77");
    readChk(255, expPal[255], "R1 R3 fmt0 e255");

    // R4: 4 entries, format 1, with gaps in the stream
    loadPal(3'd1, 1'b0, 2'd1, 1'b0, 4, 32'h8ACE_0246, 1'b1, "R1 depth1");
    for (int i = 0; i < 4; i++) readChk(i, expPal[i], "R4 fmt1");
    readChk(4, model(srcMem[4], 2'd0, 1'b0), "R1 entry 4 untouched");

    // R5: 16 entries, format 2
    loadPal(3'd2, 1'b0, 2'd2, 1'b0, 16, 32'hDEAD_BEEF, 1'b0, "R1 depth2");
    for (int i = 0; i < 16; i += 5) readChk(i, expPal[i], "R5 fmt2");

    // R6: format 3
    loadPal(3'd1, 1'b0, 2'd3, 1'b0, 4, 32'h0F1E_2D3C, 1'b0, "R6 load");
    for (int i = 0; i < 4; i++) readChk(i, expPal[i], "R6 fmt3");

    // R7: monochrome override in format 2
    loadPal(3'd1, 1'b0, 2'd2, 1'b1, 4, 32'h5A5A_1234, 1'b0, "R7 load");
    for (int i = 0; i < 4; i++) readChk(i, expPal[i], "R7 mono");

    // R2: depth code 9 is unsupported, palette stays as it was
    loadPal(3'd1, 1'b1, 2'd3, 1'b0, 4, 32'hFFFF_FFFF, 1'b0, "R2 code9");
    for (int i = 0; i < 4; i++) readChk(i, expPal[i], "R2 unchanged");

    // R9: load in format 0, then re-convert to format 3
    loadPal(3'd1, 1'b0, 2'd0, 1'b0, 4, 32'h2468_ACE1, 1'b0, "R9 load");
    @(negedge clk);
    palFmt = 2'd3; frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    begin
      int k = 0;
      while (!done && k < 20) begin @(negedge clk); k++; end
      chk(k == 4, "R9 replay cycles", 32'(k), 4);
    end
    for (int i = 0; i < 4; i++) begin
      expPal[i] = model(srcMem[i], 2'd3, 1'b0);
      readChk(i, expPal[i], "R9 reconverted");
    end
    // R9: same format, frameStart has no effect
    @(negedge clk);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    begin
      bit seen = 0;
      for (int i = 0; i < 8; i++) begin @(negedge clk); if (done) seen = 1; end
      chk(!seen, "R9 no replay same fmt", 32'(seen), 0);
    end
    readChk(2, expPal[2], "R9 unchanged same fmt");

    // R10: a read and a write of entry 0 in the same cycle
    @(negedge clk);
    depthLo = 3'd1; depthHi = 1'b0; palFmt = 2'd0; mono = 1'b0; loadStart = 1'b1;
    @(negedge clk);
    loadStart = 1'b0; rdIdx = 8'd0; srcWord = 32'h00AB_CDEF; srcValid = 1'b1;
    @(negedge clk);
    srcValid = 1'b0;
    chk(rdEntry == expPal[0], "R10 old on collision", 32'(rdEntry), 32'(expPal[0]));
    @(negedge clk);
    chk(rdEntry == model(32'h00AB_CDEF, 2'd0, 1'b0), "R10 new next cycle",
        32'(rdEntry), 32'(model(32'h00AB_CDEF, 2'd0, 1'b0)));

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule